// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide register interface of a three-channel interval timer. It decodes a four-address bus. Addresses 0, 1 and 2 give data access to channels 0, 1 and 2. Address 3 takes control words and is write-only. For each channel the block tracks the programmed access format, counting mode and decimal flag. It orders the low and high bytes of data writes and data reads. It also holds a captured count and a captured status byte until software reads them out.

The counters are outside this block. Each channel receives a one-cycle load pulse carrying a 16-bit value, together with its current counting mode and decimal flag. Each channel returns its live count and its output level. Read data is combinational from the current address and state. A read strobe consumes its byte at the clock edge that ends the read cycle.

Top module: `tmr_bus_front`

## Requirements
- R1: After reset no capture is pending. Every channel is in word format (code 3) with mode 0 and the decimal flag clear. The next data write is the low byte, the next live read returns the low byte, and no load pulse is raised.
- R2: A write to address 3 whose bits 7:6 are 0 to 2 and whose bits 5:4 are not 0 programs the addressed channel. Bits 5:4 set the format (1 low byte only, 2 high byte only, 3 low then high), bits 3:1 set the mode and bit 0 sets the decimal flag. The write also restarts that channel's write and read byte order at the low byte. The new mode and flag appear on the outputs from the next cycle.
- R3: A write to address 3 with bits 5:4 equal to 0 captures the addressed channel's live count in the current format, and leaves its mode, flag and format unchanged.
- R4: A write to address 3 with bits 7:6 equal to 3 is a multi-channel capture. Bit 1 selects channel 0, bit 2 channel 1 and bit 3 channel 2. Bit 5 at 0 captures the count and bit 4 at 0 captures the status.
- R5: The status byte holds the output level in bit 7, zero in bit 6, the format in bits 5:4, the mode in bits 3:1 and the decimal flag in bit 0. All values are taken at the capture edge.
- R6: A count capture or a status capture is ignored while an earlier capture of the same kind on that channel is still unread.
- R7: A data read returns a pending status first, then a pending captured count, and otherwise the live count. Reading the status does not disturb a pending count.
- R8: A data write in low-only format loads {8'h00, byte}, and one in high-only format loads {byte, 8'h00}. In word format the first byte is held and the second loads {second, first}. The load pulse and value appear in the cycle after the completing write.
- R9: In word format, live reads alternate low then high. A captured word is released only after its high byte is read. In the byte-only formats a single read releases the capture.
- R10: A read of address 3 returns 0 and changes no state. Each channel keeps its own byte order, so accesses to other channels in between do not disturb it.
- R11: A read and a write in the same cycle act independently. The read returns the state from before the edge and advances the read order, while the write advances the write order or completes a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address (0-2 channel data, 3 control) |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe, consumes the byte at the clock edge |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Read data for the current address |
| liveCnt | input | 48 | Live counts, channel i in bits 16i+15:16i |
| chOut | input | 3 | Output level of each channel |
| ldStb | output | 3 | One-cycle load pulse per channel |
| ldVal | output | 48 | Load value, channel i in bits 16i+15:16i |
| chMode | output | 9 | Counting mode, channel i in bits 3i+2:3i |
| chBcd | output | 3 | Decimal flag per channel |

## Verification
Two functions can share a cycle: a data read and a data write to the same channel's word-format port. The read consumes one byte of the read order while the write holds or completes the other byte order. The bench drives both strobes together in a word-format channel, and then runs a long random mix that includes simultaneous strobes. On every clock, a behavioural model decides the returned byte from the state before the edge, and decides the load pulse from the write order alone. Mixing captures with simultaneous strobes shows any cross-talk between the two orders as a wrong byte or a wrong load value.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
  localparam int NUM_CH = 3;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(3);

  typedef enum logic [1:0] {
    ACC_CAPTURE = 2'd0,
    ACC_LOW     = 2'd1,
    ACC_HIGH    = 2'd2,
    ACC_WORD    = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    LT_EMPTY = 2'd0,
    LT_LOW   = 2'd1,
    LT_HIGH  = 2'd2,
    LT_WORD  = 2'd3
  } latch_e;

  typedef struct packed {
    logic [NUM_CH-1:0] cfgWr;
    logic [NUM_CH-1:0] cntCap;
    logic [NUM_CH-1:0] stsCap;
    logic [NUM_CH-1:0] dataWr;
    logic [NUM_CH-1:0] dataRd;
  } strb_t;
endpackage

// File: rtl/tbf_ctrl.sv
module tbf_ctrl
  import tbf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWData,
  output strb_t             strb
);
  logic [1:0] ctlSel;
  logic [1:0] ctlAcc;
  logic       isCtrl;

  assign ctlSel = busWData[7:6];
  assign ctlAcc = busWData[5:4];
  assign isCtrl = (busAddr == CTRL_ADDR);

  always_comb begin
    strb = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (busWr && isCtrl) begin
        if (ctlSel == 2'd3) begin
          // multi-channel capture: select bits sit above bit 0
          if (busWData[1+i]) begin
            strb.cntCap[i] = !busWData[5];
            strb.stsCap[i] = !busWData[4];
          end
        end else if (int'(ctlSel) == i) begin
          if (ctlAcc == ACC_CAPTURE) strb.cntCap[i] = 1'b1;
          else                       strb.cfgWr[i]  = 1'b1;
        end
      end
      if (!isCtrl && int'(busAddr) == i) begin
        strb.dataWr[i] = busWr;
        strb.dataRd[i] = busRd;
      end
    end
  end

  AST_ONE_PROGRAM: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.cfgWr | strb.dataWr)) else $error("program strobes"); // R2
  AST_CTRL_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && isCtrl) |-> (strb.dataRd == '0)) else $error("ctrl read"); // R10
  AST_CAPTURE_NO_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && isCtrl && ctlAcc == ACC_CAPTURE) |-> (strb.cfgWr == '0)) else $error("capture cfg"); // R3
endmodule

// File: rtl/tbf_chan.sv
module tbf_chan
  import tbf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              cntCap,
  input  logic              stsCap,
  input  logic              dataWr,
  input  logic              dataRd,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [CNT_W-1:0]  liveCnt,
  input  logic              outLvl,
  output logic [BYTE_W-1:0] rdByte,
  output logic              ldStb,
  output logic [CNT_W-1:0]  ldVal,
  output logic [MODE_W-1:0] mode,
  output logic              bcd
);
  acc_e              acc;
  logic [MODE_W-1:0] modeR;
  logic              bcdR;
  logic              wrHi;
  logic [BYTE_W-1:0] holdB;
  logic              rdHi;
  latch_e            cl;
  logic [CNT_W-1:0]  clv;
  logic              stsV;
  logic [BYTE_W-1:0] sts;
  logic              ldStbR;
  logic [CNT_W-1:0]  ldValR;
  logic              cntRead;

  assign cntRead = dataRd && !stsV && (cl != LT_EMPTY);

  always_comb begin
    if (stsV) begin
      rdByte = sts;
    end else begin
      unique case (cl)
        LT_LOW, LT_WORD: rdByte = clv[BYTE_W-1:0];
        LT_HIGH:         rdByte = clv[CNT_W-1:BYTE_W];
        default: begin
          if (acc == ACC_HIGH || (acc == ACC_WORD && rdHi)) rdByte = liveCnt[CNT_W-1:BYTE_W];
          else                                              rdByte = liveCnt[BYTE_W-1:0];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= ACC_WORD;
      modeR  <= '0;
      bcdR   <= 1'b0;
      wrHi   <= 1'b0;
      holdB  <= '0;
      rdHi   <= 1'b0;
      cl     <= LT_EMPTY;
      clv    <= '0;
      stsV   <= 1'b0;
      sts    <= '0;
      ldStbR <= 1'b0;
      ldValR <= '0;
    end else begin
      ldStbR <= 1'b0;
      if (cfgWr) begin
        acc   <= acc_e'(wrData[5:4]);
        modeR <= wrData[3:1];
        bcdR  <= wrData[0];
        wrHi  <= 1'b0;
        rdHi  <= 1'b0;
      end
      if (dataWr) begin
        unique case (acc)
          ACC_HIGH: begin
            ldStbR <= 1'b1;
            ldValR <= {wrData, {BYTE_W{1'b0}}};
          end
          ACC_WORD: begin
            if (!wrHi) begin
              holdB <= wrData;
              wrHi  <= 1'b1;
            end else begin
              ldStbR <= 1'b1;
              ldValR <= {wrData, holdB};
              wrHi   <= 1'b0;
            end
          end
          default: begin
            ldStbR <= 1'b1;
            ldValR <= {{BYTE_W{1'b0}}, wrData};
          end
        endcase
      end
      if (cntRead) begin
        cl <= (cl == LT_WORD) ? LT_HIGH : LT_EMPTY;
      end else if (cntCap && cl == LT_EMPTY) begin
        clv <= liveCnt;
        cl  <= latch_e'(acc);
      end
      if (dataRd && !stsV && cl == LT_EMPTY && acc == ACC_WORD) rdHi <= !rdHi;
      if (dataRd && stsV) begin
        stsV <= 1'b0;
      end else if (stsCap && !stsV) begin
        sts  <= {outLvl, 1'b0, acc, modeR, bcdR};
        stsV <= 1'b1;
      end
    end
  end

  assign ldStb = ldStbR;
  assign ldVal = ldValR;
  assign mode  = modeR;
  assign bcd   = bcdR;

  AST_STS_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stsV && !dataRd) |=> (stsV && $stable(sts))) else $error("status recaptured"); // R6
  AST_CNT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (cl != LT_EMPTY && !cntRead) |=> ($stable(clv) && $stable(cl))) else $error("count recaptured"); // R6
  AST_STS_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && stsV && cl != LT_EMPTY) |=> $stable(cl)) else $error("status priority"); // R7
  AST_WORD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && acc == ACC_WORD && wrHi) |=> (ldStb && ldVal[BYTE_W-1:0] == $past(holdB))) else $error("word load"); // R8
  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && acc == ACC_WORD && !wrHi) |=> !ldStb) else $error("early load"); // R8
  AST_WORD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (cntRead && cl == LT_WORD) |=> (cl == LT_HIGH)) else $error("word release"); // R9
endmodule

// File: rtl/tbf_datapath.sv
module tbf_datapath
  import tbf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strb_t                    strb,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [BYTE_W-1:0]        busWData,
  input  logic [NUM_CH*CNT_W-1:0]  liveCnt,
  input  logic [NUM_CH-1:0]        chOut,
  output logic [BYTE_W-1:0]        busRData,
  output logic [NUM_CH-1:0]        ldStb,
  output logic [NUM_CH*CNT_W-1:0]  ldVal,
  output logic [NUM_CH*MODE_W-1:0] chMode,
  output logic [NUM_CH-1:0]        chBcd
);
  logic [BYTE_W-1:0] chByte [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tbf_chan i_chan (
      .clk    (clk),
      .rstN   (rstN),
      .cfgWr  (strb.cfgWr[g]),
      .cntCap (strb.cntCap[g]),
      .stsCap (strb.stsCap[g]),
      .dataWr (strb.dataWr[g]),
      .dataRd (strb.dataRd[g]),
      .wrData (busWData),
      .liveCnt(liveCnt[g*CNT_W +: CNT_W]),
      .outLvl (chOut[g]),
      .rdByte (chByte[g]),
      .ldStb  (ldStb[g]),
      .ldVal  (ldVal[g*CNT_W +: CNT_W]),
      .mode   (chMode[g*MODE_W +: MODE_W]),
      .bcd    (chBcd[g])
    );
  end

  always_comb begin
    busRData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(busAddr) == i) busRData = chByte[i];
    end
  end

  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == CTRL_ADDR) |-> (busRData == '0)) else $error("ctrl read data"); // R10
endmodule

// File: rtl/tmr_bus_front.sv
module tmr_bus_front
  import tbf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWr,
  input  logic                     busRd,
  input  logic [BYTE_W-1:0]        busWData,
  output logic [BYTE_W-1:0]        busRData,
  input  logic [NUM_CH*CNT_W-1:0]  liveCnt,
  input  logic [NUM_CH-1:0]        chOut,
  output logic [NUM_CH-1:0]        ldStb,
  output logic [NUM_CH*CNT_W-1:0]  ldVal,
  output logic [NUM_CH*MODE_W-1:0] chMode,
  output logic [NUM_CH-1:0]        chBcd
);
  strb_t strb;

  tbf_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .busWData(busWData),
    .strb    (strb)
  );

  tbf_datapath i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busAddr (busAddr),
    .busWData(busWData),
    .liveCnt (liveCnt),
    .chOut   (chOut),
    .busRData(busRData),
    .ldStb   (ldStb),
    .ldVal   (ldVal),
    .chMode  (chMode),
    .chBcd   (chBcd)
  );
endmodule

// File: tb/test_tmr_bus_front.sv
module test_tmr_bus_front;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  busAddr;
  logic        busWr, busRd;
  logic [7:0]  busWData, busRData;
  logic [47:0] liveCnt;
  logic [2:0]  chOut, ldStb, chBcd;
  logic [47:0] ldVal;
  logic [8:0]  chMode;
  logic [15:0] live [3];

  always #10 clk = ~clk;

  assign liveCnt = {live[2], live[1], live[0]};
  assign chOut   = {live[2][2], live[1][2], live[0][2]};

  tmr_bus_front i_tmr_bus_front (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWData(busWData), .busRData(busRData), .liveCnt(liveCnt), .chOut(chOut),
    .ldStb(ldStb), .ldVal(ldVal), .chMode(chMode), .chBcd(chBcd)
  );

  // behavioural reference state
  int mAcc[3], mMode[3], mBcd[3], mWrHi[3], mHold[3], mRdHi[3];
  int mCl[3], mClv[3], mSv[3], mSts[3], mLd[3], mLdVal[3];
  int checks = 0, errors = 0;
  bit done = 0;
  string req = "R1";

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int expRead(int a);
    int v;
    if (a == 3) return 0;
    if (mSv[a] != 0) return mSts[a];
    if (mCl[a] == 1 || mCl[a] == 3) return mClv[a] & 255;
    if (mCl[a] == 2) return (mClv[a] >> 8) & 255;
    v = int'(live[a]);
    if (mAcc[a] == 2 || (mAcc[a] == 3 && mRdHi[a] != 0)) return (v >> 8) & 255;
    return v & 255;
  endfunction

  task automatic modelStep(int a, bit w, bit r, int d);
    for (int i = 0; i < 3; i++) mLd[i] = 0;
    if (r && a < 3) begin
      if (mSv[a] != 0) mSv[a] = 0;
      else if (mCl[a] != 0) mCl[a] = (mCl[a] == 3) ? 2 : 0;
      else if (mAcc[a] == 3) mRdHi[a] = 1 - mRdHi[a];
    end
    if (w && a == 3) begin
      int ch = (d >> 6) & 3;
      int ac = (d >> 4) & 3;
      for (int i = 0; i < 3; i++) begin
        bit capC = 0, capS = 0;
        if (ch == 3 && ((d >> (i + 1)) & 1) != 0) begin
          capC = ((d >> 5) & 1) == 0;
          capS = ((d >> 4) & 1) == 0;
        end
        if (ch == i && ac == 0) capC = 1;
        if (capC && mCl[i] == 0) begin
          mCl[i] = mAcc[i];
          mClv[i] = int'(live[i]);
        end
        if (capS && mSv[i] == 0) begin
          mSts[i] = (int'(live[i][2]) << 7) | (mAcc[i] << 4) | (mMode[i] << 1) | mBcd[i];
          mSv[i] = 1;
        end
        if (ch == i && ac != 0) begin
          mAcc[i] = ac; mMode[i] = (d >> 1) & 7; mBcd[i] = d & 1;
          mWrHi[i] = 0; mRdHi[i] = 0;
        end
      end
    end else if (w) begin
      if (mAcc[a] == 2) begin mLd[a] = 1; mLdVal[a] = (d & 255) << 8; end
      else if (mAcc[a] == 3) begin
        if (mWrHi[a] == 0) begin mHold[a] = d & 255; mWrHi[a] = 1; end
        else begin mLd[a] = 1; mLdVal[a] = ((d & 255) << 8) | mHold[a]; mWrHi[a] = 0; end
      end else begin mLd[a] = 1; mLdVal[a] = d & 255; end
    end
  endtask

  task automatic cyc(int a, bit w, bit r, int d);
    @(negedge clk);
    busAddr = 2'(a); busWr = w; busRd = r; busWData = 8'(d);
    #2;
    if (r) chk("rdData", int'(busRData), expRead(a));
    for (int i = 0; i < 3; i++) begin
      chk("ldStb", int'(ldStb[i]), mLd[i]);
      if (mLd[i] != 0) chk("ldVal", int'(ldVal[i*16 +: 16]), mLdVal[i]);
      chk("mode", int'(chMode[i*3 +: 3]), mMode[i]);
      chk("bcd", int'(chBcd[i]), mBcd[i]);
    end
    @(posedge clk);
    #1;
    modelStep(a, w, r, d);
    for (int i = 0; i < 3; i++) live[i] = live[i] - 16'(i + 1);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busAddr = 0; busWr = 0; busRd = 0; busWData = 0;
    live[0] = 16'h1234; live[1] = 16'h8001; live[2] = 16'h00F0;
    for (int i = 0; i < 3; i++) begin
      mAcc[i] = 3; mMode[i] = 0; mBcd[i] = 0; mWrHi[i] = 0; mHold[i] = 0; mRdHi[i] = 0;
      mCl[i] = 0; mClv[i] = 0; mSv[i] = 0; mSts[i] = 0; mLd[i] = 0; mLdVal[i] = 0;
    end
    repeat (3) @(negedge clk);
    req = "R1";
    chk("reset ldStb", int'(ldStb), 0);
    chk("reset mode", int'(chMode), 0);
    rstN = 1'b1;
    // R1: word format, low byte first
    cyc(0, 0, 1, 0); cyc(0, 0, 1, 0); cyc(1, 0, 1, 0); cyc(1, 0, 1, 0);
    cyc(0, 1, 0, 8'h01); cyc(0, 1, 0, 8'h02); idle(1);

    req = "R2";
    cyc(3, 1, 0, 8'h34); cyc(3, 1, 0, 8'h57); cyc(3, 1, 0, 8'hA0); idle(1);

    req = "R8";
    cyc(0, 1, 0, 8'h12); cyc(0, 1, 0, 8'h34); idle(1);
    cyc(1, 1, 0, 8'hAB); cyc(2, 1, 0, 8'hCD); idle(1);

    req = "R9";
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, 0);
    cyc(1, 0, 1, 0); cyc(1, 0, 1, 0); cyc(2, 0, 1, 0); cyc(2, 0, 1, 0);

    req = "R3";
    cyc(3, 1, 0, 8'h00); idle(2);
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, 0);
    cyc(3, 1, 0, 8'h40); idle(1); cyc(1, 0, 1, 0); cyc(1, 0, 1, 0);

    req = "R6";
    cyc(3, 1, 0, 8'h00); idle(2); cyc(3, 1, 0, 8'h00); idle(2);
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, 0);

    req = "R4";
    cyc(3, 1, 0, 8'hC2); idle(1);
    for (int k = 0; k < 4; k++) cyc(0, 0, 1, 0);
    cyc(3, 1, 0, 8'hEE); idle(1);
    for (int k = 0; k < 3; k++) begin cyc(k, 0, 1, 0); cyc(k, 0, 1, 0); end
    cyc(3, 1, 0, 8'hDC); idle(1);
    cyc(1, 0, 1, 0); cyc(2, 0, 1, 0); cyc(1, 0, 1, 0);

    req = "R5";
    cyc(3, 1, 0, 8'hBB); cyc(3, 1, 0, 8'hE8); cyc(2, 0, 1, 0); cyc(2, 0, 1, 0);

    req = "R7";
    cyc(3, 1, 0, 8'hC2); idle(1); cyc(0, 0, 1, 0);
    cyc(3, 1, 0, 8'hE2); idle(1);
    for (int k = 0; k < 5; k++) cyc(0, 0, 1, 0);

    req = "R6";
    cyc(3, 1, 0, 8'hE2); idle(3); cyc(3, 1, 0, 8'hE2); cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);

    req = "R10";
    cyc(3, 0, 1, 0); cyc(3, 0, 1, 0);
    cyc(0, 1, 0, 8'h55); cyc(1, 0, 1, 0); cyc(1, 1, 0, 8'h09); cyc(0, 1, 0, 8'h66); idle(1);
    cyc(0, 0, 1, 0); cyc(2, 0, 1, 0); cyc(0, 0, 1, 0);

    req = "R11";
    cyc(0, 1, 1, 8'h77); cyc(0, 1, 1, 8'h88); idle(1);
    cyc(0, 1, 1, 8'h99); cyc(3, 1, 1, 8'h36); cyc(0, 1, 1, 8'hAA); cyc(0, 1, 1, 8'hBB); idle(1);
    for (int k = 0; k < 400; k++) begin
      int a = $urandom_range(0, 3);
      int d = $urandom_range(0, 255);
      if (a == 3 && ((d >> 6) & 3) != 3 && ((d >> 4) & 3) == 0 && $urandom_range(0, 1) == 0)
        d = d | 8'h30;
      cyc(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), d);
    end
    idle(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule